// File: doc/BRIEF.md
# HDLC Data-Link Receiver with Ping-Pong Message Buffer

This block takes a serial HDLC data-link bit stream, one bit in each cycle where `bit_en` is high. It finds flag octets (0x7E), drops the zero inserted after five ones, packs the bits into bytes with the least significant bit first, and runs a CRC-16 over each frame. The recovered bytes go into a small message store of `2**ADDR_W` locations, eight by default. The store is handled as two halves that the processor empties in turn.

An interrupt is raised each time a half fills and again when a message closes. The processor samples three live status fields: an idle indication, the last location written and a bad-check bit. It acknowledges the interrupt with a one-cycle `stat_rd` pulse and fetches bytes through a combinational read port. A message always begins in the half opposite to the one holding the last byte of the previous message, so the processor has a full half-time to drain what it was told about. Because the closing flag is the only thing that marks the last two bytes as the check sequence, a message can end exactly on a half boundary, or its check bytes can straddle two halves; both cases are reported with defined status values.

Top module: `hdlc_rx_split`

## Requirements
- R1: While reset is held and after it is released, `irq`=0, `stat_idle`=0 and `stat_badfcs`=0, and `stat_last` reads 7, so the first message is stored from location 0.
- R2: A received flag (bits 0,1,1,1,1,1,1,0 in arrival order) sets `stat_idle` to 1, also when no frame is open.
- R3: Inside a frame, a 0 that follows five consecutive 1s is dropped and takes no part in byte assembly or the check.
- R4: Each recovered byte takes its first-arriving bit as bit 0. It is stored at consecutive ascending locations, wrapping from 7 to 0, and `rd_data` returns location `rd_addr` in the same cycle.
- R5: A write to location 3 or 7 raises `irq`, and the status then shows `stat_idle`=0 and `stat_last`=3 or 7.
- R6: A `stat_rd` pulse clears `irq`. If another event arrived while `irq` was already high, `irq` is high again in the cycle after the pulse.
- R7: A closing flag after two or more bytes raises `irq` with `stat_idle`=1 and `stat_last` equal to the highest location written. The two most recently written locations hold the received check bytes, low byte first.
- R8: The check is CRC-16 (x^16+x^12+x^5+1, bit-reflected, preset 0xFFFF) over the data and check bytes. `stat_badfcs` becomes 1 at the closing flag unless the residue equals 0xF0B8. It returns to 0 when the next message is first written.
- R9: A new message starts at location 0 if `stat_last` is 4 to 7, and at location 4 if it is 0 to 3.
- R10: When the closing flag follows directly after a half fills, the end-of-message status repeats `stat_last`=3 or 7.
- R11: When the check bytes straddle the two halves, the end-of-message status shows `stat_last`=0 or 4.
- R12: Seven consecutive 1s inside a frame abort it. No end-of-message interrupt is raised, and bytes already stored stay in place.
- R13: A frame with fewer than two bytes between flags is dropped. It causes no store write, no interrupt and no change of `stat_last`.
- R14: In cycles with `bit_en` low, `bit_in` is ignored and no status field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial line bit |
| stat_rd | input | 1 | Status-read strobe, acknowledges the interrupt |
| irq | output | 1 | Interrupt request |
| stat_idle | output | 1 | 1 when the link has shown a flag since the last byte |
| stat_last | output | ADDR_W | Last store location written |
| stat_badfcs | output | 1 | Check result of the last closed message |
| rd_addr | input | ADDR_W | Store read address |
| rd_data | output | 8 | Store contents at `rd_addr` |

## Verification
A write pointer that drifts shows up within one half (four bytes) as either a missing or early interrupt, or a `stat_last` value that disagrees with the count of bytes sent, together with wrong bytes in the half just reported. A corrupted check register stays hidden until the closing flag, where it flips `stat_badfcs` on frames that are known to be good or known to be damaged. A lost pending event shows in the very cycle after a status read, because `irq` fails to come back. Wrong half selection is caught at the first store read of the next message.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam logic [15:0] FCS_PRESET  = 16'hFFFF;
    localparam logic [15:0] FCS_POLY_RF = 16'h8408;
    localparam logic [15:0] FCS_RESIDUE = 16'hF0B8;

    function automatic logic [15:0] fcs_step(input logic [15:0] crc, input logic [BYTE_W-1:0] data);
        logic [15:0] c;
        c = crc;
        for (int i = 0; i < BYTE_W; i++) begin
            if (c[0] ^ data[i]) c = (c >> 1) ^ FCS_POLY_RF;
            else                c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              bit_in,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_data,
    output logic              flag_ev,
    output logic              abort_ev
);
    localparam int unsigned CNT_W     = $clog2(BYTE_W);
    localparam logic [2:0]  STUFF_RUN = 3'd5;
    localparam logic [2:0]  FLAG_RUN  = 3'd6;
    localparam logic [2:0]  SAT_RUN   = 3'd7;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic              sync;
        logic [2:0]        ones;
        logic [CNT_W-1:0]  nbit;
        logic [BYTE_W-1:0] sh;
    } df_t;

    df_t q, d;
    logic is_data;

    always_comb begin
        d         = q;
        is_data   = 1'b0;
        byte_vld  = 1'b0;
        flag_ev   = 1'b0;
        abort_ev  = 1'b0;
        byte_data = {bit_in, q.sh[BYTE_W-1:1]};
        if (bit_en) begin
            if (bit_in) begin
                if (q.ones == FLAG_RUN) begin
                    abort_ev = q.sync;
                    d.sync   = 1'b0;
                    d.ones   = SAT_RUN;
                end else begin
                    if (q.ones != SAT_RUN) d.ones = q.ones + 3'd1;
                    is_data = 1'b1;
                end
            end else begin
                d.ones = 3'd0;
                if (q.ones == FLAG_RUN) begin
                    flag_ev = 1'b1;
                    d.sync  = 1'b1;
                    d.nbit  = '0;
                end else if (q.ones != STUFF_RUN) begin
                    is_data = 1'b1;
                end
            end
            if (is_data && q.sync) begin
                d.sh   = {bit_in, q.sh[BYTE_W-1:1]};
                d.nbit = q.nbit + 1'b1;
                byte_vld = (q.nbit == LAST_BIT);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/hdlc_rx_fcs.sv
module hdlc_rx_fcs
    import hdlc_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              upd,
    input  logic [BYTE_W-1:0] din,
    output logic              good
);
    logic [15:0] crc_q, crc_d;

    always_comb begin
        crc_d = crc_q;
        if (clr)      crc_d = FCS_PRESET;
        else if (upd) crc_d = fcs_step(crc_q, din);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= FCS_PRESET;
        else        crc_q <= crc_d;
    end

    assign good = (crc_q == FCS_RESIDUE);

endmodule

// File: rtl/hdlc_rx_msgbuf.sv
module hdlc_rx_msgbuf
    import hdlc_rx_pkg::*;
#(
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_a,
    input  logic [ADDR_W-1:0] wa_a,
    input  logic [BYTE_W-1:0] wd_a,
    input  logic              we_b,
    input  logic [ADDR_W-1:0] wa_b,
    input  logic [BYTE_W-1:0] wd_b,
    input  logic [ADDR_W-1:0] ra,
    output logic [BYTE_W-1:0] rd
);
    localparam int unsigned DEPTH = 2 ** ADDR_W;

    logic [BYTE_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_loc
        always_ff @(posedge clk) begin
            if (!rst_n)                                mem[i] <= '0;
            else if (we_b && (wa_b == ADDR_W'(i)))     mem[i] <= wd_b;
            else if (we_a && (wa_a == ADDR_W'(i)))     mem[i] <= wd_a;
        end
    end

    assign rd = mem[ra];

endmodule

// File: rtl/hdlc_rx_split.sv
module hdlc_rx_split
    import hdlc_rx_pkg::*;
#(
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              bit_in,
    input  logic              stat_rd,
    output logic              irq,
    output logic              stat_idle,
    output logic [ADDR_W-1:0] stat_last,
    output logic              stat_badfcs,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data
);
    localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] TWO_A = ADDR_W'(2);
    localparam logic [1:0] NB_NONE = 2'd0;
    localparam logic [1:0] NB_HELD = 2'd1;

    typedef struct packed {
        logic [1:0]        nb;
        logic [BYTE_W-1:0] hold;
        logic [ADDR_W-1:0] wp;
        logic [ADDR_W-1:0] last;
        logic              idle;
        logic              bad;
        logic              irq;
        logic              pend;
    } ctl_t;

    ctl_t q, d;

    logic              byte_vld, flag_ev, abort_ev, fcs_good;
    logic [BYTE_W-1:0] byte_data;
    logic              we_a, we_b, half_ev, eom_ev, ev;
    logic [ADDR_W-1:0] wa_a, wa_b, base;
    logic [BYTE_W-1:0] wd_a, wd_b;
    logic              pend_w;

    hdlc_rx_deframer u_dfr (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .byte_vld(byte_vld), .byte_data(byte_data),
        .flag_ev(flag_ev), .abort_ev(abort_ev)
    );

    hdlc_rx_fcs u_fcs (
        .clk(clk), .rst_n(rst_n), .clr(flag_ev), .upd(byte_vld),
        .din(byte_data), .good(fcs_good)
    );

    hdlc_rx_msgbuf #(.ADDR_W(ADDR_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .we_a(we_a), .wa_a(wa_a), .wd_a(wd_a),
        .we_b(we_b), .wa_b(wa_b), .wd_b(wd_b),
        .ra(rd_addr), .rd(rd_data)
    );

    always_comb begin
        d       = q;
        we_a    = 1'b0;
        we_b    = 1'b0;
        wa_a    = '0;
        wa_b    = q.wp;
        wd_a    = q.hold;
        wd_b    = byte_data;
        half_ev = 1'b0;
        eom_ev  = 1'b0;
        base    = {~q.last[ADDR_W-1], {(ADDR_W-1){1'b0}}};

        if (abort_ev) begin
            d.nb = NB_NONE;
        end else if (flag_ev) begin
            d.idle = 1'b1;
            if (q.nb > NB_HELD) begin
                eom_ev = 1'b1;
                d.bad  = ~fcs_good;
            end
            d.nb = NB_NONE;
        end else if (byte_vld) begin
            if (q.nb == NB_NONE) begin
                d.hold = byte_data;
                d.nb   = NB_HELD;
            end else if (q.nb == NB_HELD) begin
                we_a   = 1'b1;
                wa_a   = base;
                we_b   = 1'b1;
                wa_b   = base + ONE_A;
                d.last = base + ONE_A;
                d.wp   = base + TWO_A;
                d.nb   = 2'd2;
                d.idle = 1'b0;
                d.bad  = 1'b0;
                half_ev = &wa_b[ADDR_W-2:0];
            end else begin
                we_b    = 1'b1;
                d.last  = q.wp;
                d.wp    = q.wp + ONE_A;
                half_ev = &q.wp[ADDR_W-2:0];
            end
        end

        ev = half_ev | eom_ev;
        if (stat_rd) begin
            d.irq  = q.pend | ev;
            d.pend = q.pend & ev;
        end else if (ev) begin
            if (q.irq) d.pend = 1'b1;
            else       d.irq  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.last <= '1;
        end else begin
            q <= d;
        end
    end

    assign irq         = q.irq;
    assign stat_idle   = q.idle;
    assign stat_last   = q.last;
    assign stat_badfcs = q.bad;
    assign pend_w      = q.pend;

endmodule

// File: rtl/hdlc_rx_split_chk.sv
module hdlc_rx_split_chk #(
    parameter int unsigned ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_en,
    input logic              stat_rd,
    input logic              irq,
    input logic              stat_idle,
    input logic [ADDR_W-1:0] stat_last,
    input logic              stat_badfcs,
    input logic              pend
);
    // R14
    last_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(stat_last));

    // R14
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(stat_idle));

    // R8
    bad_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_badfcs |-> stat_idle);

    // R6
    pend_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> irq);

    // R6
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !pend && !bit_en) |=> !irq);

    // R5
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(bit_en) || $past(stat_rd)));

endmodule

bind hdlc_rx_split hdlc_rx_split_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .stat_rd(stat_rd),
    .irq(irq), .stat_idle(stat_idle), .stat_last(stat_last),
    .stat_badfcs(stat_badfcs), .pend(pend_w)
);

// File: tb/hdlc_rx_split_bench.sv
module hdlc_rx_split_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b0;
    logic       stat_rd = 1'b0;
    logic       irq, stat_idle, stat_badfcs;
    logic [2:0] stat_last;
    logic [2:0] rd_addr = 3'd0;
    logic [7:0] rd_data;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int ones = 0;
    int exp_last = 7;
    logic [7:0] exp_mem [8];
    logic [7:0] dat [16];
    logic [7:0] fr [18];

    always #2 clk = ~clk;

    hdlc_rx_split u_hdlc_rx_split (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .stat_rd(stat_rd), .irq(irq), .stat_idle(stat_idle),
        .stat_last(stat_last), .stat_badfcs(stat_badfcs),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input int n);
        logic [15:0] c = 16'hFFFF;
        for (int k = 0; k < n; k++) begin
            for (int b = 0; b < 8; b++) begin
                logic fb;
                fb = c[0] ^ dat[k][b];
                c = c >> 1;
                if (fb) c = c ^ 16'h8408;
            end
        end
        return c;
    endfunction

    task automatic send_bit(input logic b);
        int gap;
        gap = $urandom_range(0, 2);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            bit_en = 1'b0;
            bit_in = 1'($urandom_range(0, 1));
        end
        @(negedge clk);
        bit_in = b;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic send_flag();
        for (int i = 0; i < 8; i++) send_bit(((8'h7E >> i) & 8'h01) != 0);
        ones = 0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            send_bit(v[i]);
            if (v[i]) begin
                ones++;
                if (ones == 5) begin
                    send_bit(1'b0);
                    ones = 0;
                end
            end else begin
                ones = 0;
            end
        end
    endtask

    task automatic stat_read();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int loc);
        rd_addr = 3'(loc);
        #1;
        chk(tag, rd_data, exp_mem[loc]);
    endtask

    task automatic run_frame(input int nd, input bit corrupt, input bit service);
        logic [15:0] fcs;
        int total, base, loc, unserv;
        string tag;
        total = nd + 2;
        fcs = ~ref_crc(nd);
        for (int k = 0; k < nd; k++) fr[k] = dat[k];
        fr[nd]     = fcs[7:0] ^ (corrupt ? 8'h01 : 8'h00);
        fr[nd + 1] = fcs[15:8];
        base = (exp_last >= 4) ? 0 : 4;
        unserv = 0;
        send_flag();
        for (int k = 0; k < total; k++) begin
            send_byte(fr[k]);
            if (k >= 1) begin
                loc = (base + k) % 8;
                if (k == 1) begin
                    exp_mem[base] = fr[0];
                    exp_mem[(base + 1) % 8] = fr[1];
                    rd_chk("R9 first byte at start location", base);
                end else begin
                    exp_mem[loc] = fr[k];
                end
                exp_last = loc;
                if (loc % 4 == 3) begin
                    chk("R5 half-fill irq", irq, 1);
                    if (service) begin
                        chk("R5 idle during message", stat_idle, 0);
                        chk("R5 last at half fill", stat_last, loc);
                        for (int j = loc - 3; j <= loc; j++) rd_chk("R4 half contents", j);
                        stat_read();
                        chk("R6 read clears irq", irq, 0);
                    end else begin
                        unserv++;
                    end
                end
            end
        end
        send_flag();
        if (exp_last % 4 == 3)      tag = "R10 closing flag after half fill";
        else if (exp_last % 4 == 0) tag = "R11 check bytes straddle halves";
        else                        tag = "R7 end-of-message last";
        chk("R7 end irq", irq, 1);
        chk("R7 end idle", stat_idle, 1);
        chk(tag, stat_last, exp_last);
        chk("R8 bad check flag", stat_badfcs, corrupt ? 1 : 0);
        for (int j = exp_last & 4; j <= exp_last; j++) rd_chk("R7 final half holds bytes and check", j);
        stat_read();
        if (unserv > 0) begin
            chk("R6 pending event re-raises irq", irq, 1);
            stat_read();
        end
        chk("R6 irq clear after end", irq, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) exp_mem[i] = 8'h00;

        repeat (3) @(negedge clk);
        chk("R1 reset irq", irq, 0);
        chk("R1 reset idle", stat_idle, 0);
        chk("R1 reset badfcs", stat_badfcs, 0);
        chk("R1 reset last", stat_last, 7);
        rst_n = 1'b1;

        // R14: flag pattern presented with bit_en low
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                bit_in = ((8'h7E >> i) & 8'h01) != 0;
            end
        end
        @(negedge clk);
        chk("R14 ignored bits leave idle", stat_idle, 0);
        chk("R14 ignored bits leave irq", irq, 0);
        chk("R1 last after reset release", stat_last, 7);

        send_flag();
        send_flag();
        chk("R2 idle flag sets idle", stat_idle, 1);
        chk("R2 no irq on idle flag", irq, 0);

        // R3: patterns forcing stuffed zeros
        dat[0] = 8'h7E; dat[1] = 8'hFF; dat[2] = 8'hF8; dat[3] = 8'h1F; dat[4] = 8'h3E;
        run_frame(5, 1'b0, 1'b1);
        chk("R3 destuffed byte 0x7E", exp_mem[0], 8'h7E);

        // R10 with pending event (half fill unserviced, then close)
        dat[0] = 8'hA5; dat[1] = 8'h5A;
        run_frame(2, 1'b0, 1'b0);

        // R11: check bytes straddle halves
        dat[0] = 8'h11; dat[1] = 8'h22; dat[2] = 8'h33;
        run_frame(3, 1'b0, 1'b1);

        // R8: damaged check
        dat[0] = 8'hC3; dat[1] = 8'h00;
        run_frame(2, 1'b1, 1'b1);

        // R12: abort after three bytes
        begin
            int base;
            base = (exp_last >= 4) ? 0 : 4;
            send_flag();
            send_byte(8'h01); send_byte(8'h02); send_byte(8'h03);
            exp_mem[base] = 8'h01; exp_mem[base + 1] = 8'h02; exp_mem[base + 2] = 8'h03;
            exp_last = base + 2;
            for (int i = 0; i < 7; i++) send_bit(1'b1);
            ones = 0;
            send_flag();
            send_flag();
            chk("R12 abort raises no irq", irq, 0);
            chk("R12 abort keeps stored bytes last", stat_last, exp_last);
            rd_chk("R12 abort keeps stored byte", base + 2);
            chk("R12 idle after following flag", stat_idle, 1);
        end

        // R13: single-byte frame dropped
        begin
            int base;
            base = (exp_last >= 4) ? 0 : 4;
            send_flag();
            send_byte(8'h9C);
            send_flag();
            chk("R13 short frame no irq", irq, 0);
            chk("R13 short frame keeps last", stat_last, exp_last);
            rd_chk("R13 short frame no write", base);
        end

        for (int r = 0; r < 24; r++) begin
            int nd;
            nd = $urandom_range(0, 10);
            for (int k = 0; k < nd; k++) dat[k] = 8'($urandom_range(0, 255));
            run_frame(nd, $urandom_range(0, 3) == 0, 1'b1);
            if ($urandom_range(0, 1) == 1) send_flag();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule